// File: doc/BRIEF.md
# PCM Channel Select and Standby Controller

This block sits between a stereo PCM deserializer and an amplifier modulator. Once per audio frame it receives a signed left word, a signed right word and a one-cycle frame strobe. From these it produces a single mono sample stream, a one-cycle valid pulse per frame and an output-enable for the power stage. A three-bit thermometer code from the comparators on the mode pin picks what is played: the left word, the right word, the floor average of both, or nothing.

A free-running system clock runs the block. The serial bit clock arrives asynchronously. It is synchronised and watched by an activity monitor, which has three states: `BM_LOST`, `BM_RECOVER` and `BM_ALIVE`. The monitor moves from `BM_ALIVE` to `BM_LOST` when no rising bit-clock edge is seen for `TIMEOUT` system cycles. It moves from `BM_LOST` to `BM_RECOVER` on the first new edge. It moves from `BM_RECOVER` to `BM_ALIVE` after `RECOVER_EDGES` edges in a row, with no timeout in between. If a timeout occurs during recovery, it returns from `BM_RECOVER` to `BM_LOST`.

The playback state machine has three states: `PS_SHUTDOWN`, `PS_STANDBY` and `PS_PLAY`.
- From any state, a strobe carrying an off code moves it to `PS_SHUTDOWN`.
- From `PS_SHUTDOWN`, a strobe with a playing code moves it to `PS_PLAY` when the monitor is alive, and to `PS_STANDBY` otherwise.
- `PS_PLAY` drops to `PS_STANDBY` as soon as the monitor leaves `BM_ALIVE`.
- `PS_STANDBY` returns to `PS_PLAY` at the first strobe with a playing code after the monitor is alive again.
- Reset enters `PS_SHUTDOWN`, with the monitor in `BM_LOST`.

Top module: `pcm_chansel_standby`

## Requirements
- R1: With `mode_cmp` = 3'b111 (bit 2 is the highest comparator) sampled at a frame strobe while playing, the cycle after the strobe shows `mono_out` equal to that strobe's left word.
- R2: With `mode_cmp` = 3'b011 at a frame strobe while playing, `mono_out` equals that strobe's right word one cycle later.
- R3: With `mode_cmp` = 3'b001 at a frame strobe while playing, `mono_out` is (left + right) formed at 17 bits and shifted right arithmetically by one. The result never overflows and rounds toward minus infinity.
- R4: A frame strobe with `mode_cmp` of 3'b000, 3'b010, 3'b100, 3'b101 or 3'b110 shuts the output down from the next cycle: `out_en` = 0, `mono_out` = 0, no `mono_vld`.
- R5: A change of `mode_cmp` between frame strobes has no effect on any output until the next strobe.
- R6: While playing, each frame strobe gives exactly one `mono_vld` pulse in the following cycle. `mono_out` holds its value until the next strobe.
- R7: When no rising edge of `bclk_in` is seen for `TIMEOUT` system cycles, the output enters standby: `out_en` = 0 and `mono_out` = 0. Strobes received while the monitor is not alive do not enable the output.
- R8: After bit-clock loss, output resumes only at a frame strobe that follows `RECOVER_EDGES` consecutive rising edges. Fewer edges followed by a new timeout keep the output off.
- R9: Shutdown has priority over standby. An off-code strobe disables the output in any state, including the cycle in which bit-clock loss is detected. It also disables the output while the bit clock is recovering. Only a later playing-code strobe re-enables it.
- R10: During and right after reset, `out_en`, `mono_vld` and `mono_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous to `clk` |
| frame_stb | input | 1 | One-cycle strobe marking a new stereo frame |
| left_smp | input | SMP_W | Signed left word of the frame |
| right_smp | input | SMP_W | Signed right word of the frame |
| mode_cmp | input | 3 | Comparator outputs on the mode pin, bit 2 = highest threshold |
| mono_out | output | SMP_W | Selected mono sample, zero when disabled |
| mono_vld | output | 1 | One pulse per frame while playing |
| out_en | output | 1 | Output stage enable |

## Verification
Two functions can fall in the same clock: the bit-clock monitor declaring loss, and a frame strobe carrying an off code. The bench provokes this by stopping the bit clock and then sweeping the strobe across every offset around the timeout instant, so that in one of the trials the two coincide. A behavioural per-clock model judges each trial. After each trial the bench also checks that a recovered bit clock alone does not re-enable the output, and that a playing-code strobe does.

// File: rtl/pcmsel_pkg.sv
package pcmsel_pkg;

    typedef enum logic [1:0] {
        CH_OFF,
        CH_LEFT,
        CH_RIGHT,
        CH_MIX
    } chan_t;

    typedef enum logic [1:0] {
        PS_SHUTDOWN,
        PS_STANDBY,
        PS_PLAY
    } play_st_t;

    typedef enum logic [1:0] {
        BM_LOST,
        BM_RECOVER,
        BM_ALIVE
    } bmon_st_t;

endpackage

// File: rtl/pcmsel_mode_decode.sv
module pcmsel_mode_decode
    import pcmsel_pkg::*;
(
    input  logic [2:0] cmp,
    output chan_t      chan
);

    always_comb begin
        unique case (cmp)
            3'b111:  chan = CH_LEFT;
            3'b011:  chan = CH_RIGHT;
            3'b001:  chan = CH_MIX;
            default: chan = CH_OFF;
        endcase
    end

endmodule

// File: rtl/pcmsel_mixer.sv
module pcmsel_mixer
    import pcmsel_pkg::*;
#(
    parameter int SMP_W = 16
) (
    input  chan_t            chan,
    input  logic [SMP_W-1:0] left_smp,
    input  logic [SMP_W-1:0] right_smp,
    output logic [SMP_W-1:0] mixed
);

    localparam int SUM_W = SMP_W + 1;

    logic [SUM_W-1:0] wide_sum;

    always_comb begin
        wide_sum = {left_smp[SMP_W-1], left_smp} + {right_smp[SMP_W-1], right_smp};
        unique case (chan)
            CH_LEFT:  mixed = left_smp;
            CH_RIGHT: mixed = right_smp;
            CH_MIX:   mixed = wide_sum[SUM_W-1:1];
            default:  mixed = '0;
        endcase
    end

endmodule

// File: rtl/pcmsel_bclk_monitor.sv
module pcmsel_bclk_monitor
    import pcmsel_pkg::*;
#(
    parameter int TIMEOUT       = 64,
    parameter int RECOVER_EDGES = 4,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    output logic bclk_ok
);

    localparam int IDLE_W = $clog2(TIMEOUT + 1);
    localparam int EDGE_W = $clog2(RECOVER_EDGES + 1);
    localparam logic [IDLE_W-1:0] IDLE_MAX  = IDLE_W'(TIMEOUT);
    localparam logic [EDGE_W-1:0] EDGE_GOAL = EDGE_W'(RECOVER_EDGES);

    logic [SYNC_STAGES:0] sync_q;
    logic                 bclk_rise;
    logic                 timed_out;
    logic [IDLE_W-1:0]    idle_cnt;
    logic [EDGE_W-1:0]    edge_cnt, edge_cnt_nxt;
    bmon_st_t             mon_st, mon_st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], bclk_in};
    end

    assign bclk_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
    assign timed_out = (idle_cnt == IDLE_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               idle_cnt <= '0;
        else if (bclk_rise)       idle_cnt <= '0;
        else if (!timed_out)      idle_cnt <= idle_cnt + 1'b1;
    end

    always_comb begin
        mon_st_nxt   = mon_st;
        edge_cnt_nxt = edge_cnt;
        unique case (mon_st)
            BM_ALIVE: begin
                if (timed_out) mon_st_nxt = BM_LOST;
            end
            BM_LOST: begin
                if (bclk_rise) begin
                    edge_cnt_nxt = EDGE_W'(1);
                    mon_st_nxt   = (EDGE_GOAL == EDGE_W'(1)) ? BM_ALIVE : BM_RECOVER;
                end
            end
            BM_RECOVER: begin
                if (timed_out) begin
                    mon_st_nxt = BM_LOST;
                end else if (bclk_rise) begin
                    edge_cnt_nxt = edge_cnt + 1'b1;
                    if (edge_cnt + 1'b1 == EDGE_GOAL) mon_st_nxt = BM_ALIVE;
                end
            end
            default: mon_st_nxt = BM_LOST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_st   <= BM_LOST;
            edge_cnt <= '0;
        end else begin
            mon_st   <= mon_st_nxt;
            edge_cnt <= edge_cnt_nxt;
        end
    end

    assign bclk_ok = (mon_st == BM_ALIVE);

endmodule

// File: rtl/pcm_chansel_standby.sv
module pcm_chansel_standby
    import pcmsel_pkg::*;
#(
    parameter int SMP_W         = 16,
    parameter int TIMEOUT       = 64,
    parameter int RECOVER_EDGES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_in,
    input  logic             frame_stb,
    input  logic [SMP_W-1:0] left_smp,
    input  logic [SMP_W-1:0] right_smp,
    input  logic [2:0]       mode_cmp,
    output logic [SMP_W-1:0] mono_out,
    output logic             mono_vld,
    output logic             out_en
);

    chan_t            dec_chan;
    logic [SMP_W-1:0] mix_smp;
    logic             bclk_ok;
    play_st_t         play_st, play_st_nxt;

    pcmsel_mode_decode i_decode (
        .cmp  (mode_cmp),
        .chan (dec_chan)
    );

    pcmsel_mixer #(.SMP_W(SMP_W)) i_mixer (
        .chan      (dec_chan),
        .left_smp  (left_smp),
        .right_smp (right_smp),
        .mixed     (mix_smp)
    );

    pcmsel_bclk_monitor #(
        .TIMEOUT       (TIMEOUT),
        .RECOVER_EDGES (RECOVER_EDGES)
    ) i_monitor (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk_in (bclk_in),
        .bclk_ok (bclk_ok)
    );

    // Transition logic: an off-code strobe wins over every other condition.
    always_comb begin
        play_st_nxt = play_st;
        unique case (play_st)
            PS_SHUTDOWN: begin
                if (frame_stb && dec_chan != CH_OFF)
                    play_st_nxt = bclk_ok ? PS_PLAY : PS_STANDBY;
            end
            PS_STANDBY: begin
                if (frame_stb && dec_chan == CH_OFF)
                    play_st_nxt = PS_SHUTDOWN;
                else if (frame_stb && bclk_ok)
                    play_st_nxt = PS_PLAY;
            end
            PS_PLAY: begin
                if (frame_stb && dec_chan == CH_OFF)
                    play_st_nxt = PS_SHUTDOWN;
                else if (!bclk_ok)
                    play_st_nxt = PS_STANDBY;
            end
            default: play_st_nxt = PS_SHUTDOWN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) play_st <= PS_SHUTDOWN;
        else        play_st <= play_st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mono_out <= '0;
            mono_vld <= 1'b0;
            out_en   <= 1'b0;
        end else if (play_st_nxt == PS_PLAY) begin
            out_en   <= 1'b1;
            mono_vld <= frame_stb;
            if (frame_stb) mono_out <= mix_smp;
        end else begin
            out_en   <= 1'b0;
            mono_vld <= 1'b0;
            mono_out <= '0;
        end
    end

endmodule

// File: rtl/pcmsel_checker.sv
module pcmsel_checker #(
    parameter int SMP_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_stb,
    input logic [SMP_W-1:0] left_smp,
    input logic [SMP_W-1:0] right_smp,
    input logic [2:0]       mode_cmp,
    input logic [SMP_W-1:0] mono_out,
    input logic             mono_vld,
    input logic             out_en
);

    function automatic logic [SMP_W-1:0] floor_avg(input logic [SMP_W-1:0] a,
                                                   input logic [SMP_W-1:0] b);
        logic [SMP_W:0] s;
        s = {a[SMP_W-1], a} + {b[SMP_W-1], b};
        return s[SMP_W:1];
    endfunction

    a_r1_left_word: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && mode_cmp == 3'b111) |=> (!mono_vld || mono_out == $past(left_smp)));

    a_r2_right_word: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && mode_cmp == 3'b011) |=> (!mono_vld || mono_out == $past(right_smp)));

    a_r3_floor_mix: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && mode_cmp == 3'b001) |=>
            (!mono_vld || mono_out == floor_avg($past(left_smp), $past(right_smp))));

    a_r4_off_code: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && mode_cmp != 3'b111 && mode_cmp != 3'b011 && mode_cmp != 3'b001)
            |=> !out_en);

    a_r4_silent_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (mono_out == '0 && !mono_vld));

    a_r5_enable_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_en) |-> $past(frame_stb));

    a_r6_vld_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mono_vld |-> $past(frame_stb));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && !frame_stb) |=> (!out_en || $stable(mono_out)));

endmodule

bind pcm_chansel_standby pcmsel_checker #(.SMP_W(SMP_W)) i_pcmsel_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .left_smp  (left_smp),
    .right_smp (right_smp),
    .mode_cmp  (mode_cmp),
    .mono_out  (mono_out),
    .mono_vld  (mono_vld),
    .out_en    (out_en)
);

// File: tb/test_pcm_chansel_standby.sv
module test_pcm_chansel_standby;

    localparam int CLK_PERIOD = 10;
    localparam int SMP_W      = 16;
    localparam int TMO        = 64;
    localparam int REC        = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bclk = 1'b0;
    logic             stb = 1'b0;
    logic [SMP_W-1:0] lft = '0;
    logic [SMP_W-1:0] rgt = '0;
    logic [2:0]       mode = 3'b000;
    logic [SMP_W-1:0] mono_out;
    logic             mono_vld;
    logic             out_en;

    int    total = 0;
    int    fails = 0;
    bit    done  = 0;
    bit    bclk_run = 0;
    int    bclk_ph = 0;
    string cur_req = "R10";

    // reference model state
    bit s1, s2, s3;
    int idle, edges, mon;      // mon: 0 lost, 1 recover, 2 alive
    int st;                    // 0 shutdown, 1 standby, 2 play
    logic [SMP_W-1:0] e_out;
    bit e_vld, e_en;

    pcm_chansel_standby #(.SMP_W(SMP_W), .TIMEOUT(TMO), .RECOVER_EDGES(REC)) i_pcm_chansel_standby (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .frame_stb(stb),
        .left_smp(lft), .right_smp(rgt), .mode_cmp(mode),
        .mono_out(mono_out), .mono_vld(mono_vld), .out_en(out_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial forever begin
        @(negedge clk);
        if (bclk_run) begin
            bclk_ph++;
            if (bclk_ph == 2) begin bclk = ~bclk; bclk_ph = 0; end
        end
    end

    function automatic int chan_of(logic [2:0] c);
        case (c)
            3'b111:  return 1;
            3'b011:  return 2;
            3'b001:  return 3;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            s1 = 0; s2 = 0; s3 = 0; idle = 0; edges = 0; mon = 0; st = 0;
            e_out = '0; e_vld = 0; e_en = 0;
        end else begin
            bit rise, timed, ok;
            int ch, nst, lv, rv;
            rise  = s2 && !s3;
            timed = (idle == TMO);
            ok    = (mon == 2);
            if (mon == 2) begin
                if (timed) mon = 0;
            end else if (mon == 0) begin
                if (rise) begin edges = 1; mon = (REC == 1) ? 2 : 1; end
            end else begin
                if (timed) mon = 0;
                else if (rise) begin edges++; if (edges == REC) mon = 2; end
            end
            if (rise) idle = 0; else if (idle != TMO) idle++;
            s3 = s2; s2 = s1; s1 = bclk;
            ch  = chan_of(mode);
            nst = st;
            if (stb && ch == 0) nst = 0;
            else if (st == 0) begin if (stb) nst = ok ? 2 : 1; end
            else if (st == 1) begin if (stb && ok) nst = 2; end
            else if (!ok) nst = 1;
            st = nst;
            if (st == 2) begin
                e_en = 1; e_vld = stb;
                if (stb) begin
                    lv = $signed(lft); rv = $signed(rgt);
                    if (ch == 1) e_out = lft;
                    else if (ch == 2) e_out = rgt;
                    else e_out = SMP_W'((lv + rv) >>> 1);
                end
            end else begin
                e_en = 0; e_vld = 0; e_out = '0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (out_en !== e_en || mono_vld !== e_vld || mono_out !== e_out) begin
                fails++;
                $display("FAIL %s per-clock: en/vld/out actual %0b/%0b/%h expected %0b/%0b/%h",
                         cur_req, out_en, mono_vld, mono_out, e_en, e_vld, e_out);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic frame(input logic [SMP_W-1:0] l, input logic [SMP_W-1:0] r);
        @(negedge clk);
        lft = l; rgt = r; stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        idle_cycles(3);
        chk("R10", {mono_out, 14'b0, mono_vld, out_en}, 32'h0);
        rst_n = 1'b1;
        idle_cycles(2);
        chk("R10", {mono_out, 14'b0, mono_vld, out_en}, 32'h0);

        bclk_run = 1;
        idle_cycles(40);
        cur_req = "R1"; mode = 3'b111;
        frame(16'h1234, 16'hABCD);
        chk("R1", {mono_vld, out_en, mono_out}, {2'b11, 16'h1234});

        cur_req = "R2"; mode = 3'b011;
        frame(16'h1234, 16'hABCD);
        chk("R2", mono_out, 16'hABCD);

        cur_req = "R3"; mode = 3'b001;
        frame(16'h7FFF, 16'h7FFF); chk("R3", mono_out, 16'h7FFF);
        frame(16'h8000, 16'h8000); chk("R3", mono_out, 16'h8000);
        frame(16'hFFFF, 16'h0000); chk("R3", mono_out, 16'hFFFF);
        frame(16'h0003, 16'h0000); chk("R3", mono_out, 16'h0001);
        frame(16'hFFFD, 16'h0000); chk("R3", mono_out, 16'hFFFE);
        frame(16'h7FFF, 16'h8001); chk("R3", mono_out, 16'h0000);

        cur_req = "R5"; mode = 3'b111;
        frame(16'h0555, 16'h0AAA);
        @(negedge clk); mode = 3'b000;
        idle_cycles(6);
        chk("R5", {out_en, mono_out}, {1'b1, 16'h0555});
        mode = 3'b011;
        idle_cycles(3);
        chk("R5", mono_out, 16'h0555);

        cur_req = "R4";
        foreach (mode_list_dummy[i]) ;
        for (int i = 0; i < 5; i++) begin
            logic [2:0] bad;
            case (i)
                0: bad = 3'b000; 1: bad = 3'b010; 2: bad = 3'b100;
                3: bad = 3'b101; default: bad = 3'b110;
            endcase
            mode = 3'b111; frame(16'h0101, 16'h0202);
            mode = bad;    frame(16'h0303, 16'h0404);
            chk("R4", {mono_out, 14'b0, mono_vld, out_en}, 32'h0);
        end

        cur_req = "R6"; mode = 3'b111;
        begin
            int pulses = 0;
            for (int k = 0; k < 6; k++) begin
                frame(SMP_W'(k + 16'h100), 16'h0);
                if (mono_vld) pulses++;
                idle_cycles(3);
                if (mono_vld) pulses++;
                chk("R6", mono_out, SMP_W'(k + 16'h100));
            end
            chk("R6", pulses, 6);
        end

        cur_req = "R7";
        bclk_run = 0;
        idle_cycles(30);
        chk("R7", out_en, 1'b1);
        idle_cycles(60);
        chk("R7", {mono_out, 15'b0, out_en}, 32'h0);
        frame(16'h4444, 16'h4444);
        chk("R7", {mono_vld, out_en}, 2'b00);

        cur_req = "R8";
        bclk_run = 1;
        idle_cycles(8);
        bclk_run = 0;
        frame(16'h5555, 16'h0);
        chk("R8", out_en, 1'b0);
        idle_cycles(90);
        bclk_run = 1;
        idle_cycles(60);
        chk("R8", out_en, 1'b0);
        frame(16'h6666, 16'h0);
        chk("R8", {out_en, mono_out}, {1'b1, 16'h6666});

        cur_req = "R9";
        for (int k = 60; k <= 74; k++) begin
            bclk_run = 1; mode = 3'b111;
            idle_cycles(40);
            frame(16'h7000, 16'h0);
            bclk_run = 0;
            idle_cycles(k);
            mode = 3'b000;
            frame(16'h7001, 16'h0);
            chk("R9", out_en, 1'b0);
            bclk_run = 1;
            idle_cycles(40);
            frame(16'h7002, 16'h0);
            chk("R9", out_en, 1'b0);
            mode = 3'b111;
            frame(16'h7003, 16'h0);
            chk("R9", {out_en, mono_out}, {1'b1, 16'h7003});
        end
        bclk_run = 1; mode = 3'b111;
        idle_cycles(5);
        mode = 3'b000; frame(16'h1, 16'h1);
        bclk_run = 0;
        idle_cycles(10);
        chk("R9", out_en, 1'b0);

        idle_cycles(5);
        summary();
    end

    int mode_list_dummy[1];

endmodule